// File: doc/BRIEF.md
# BCD Calendar Counter with Coherent Date Snapshot

This block keeps the time of day and the calendar date in packed BCD. It advances one second on each cycle where the 1 Hz tick enable is high. Hours run in 24-hour form. The date carries a two-digit year offset, a month, a day and a weekday code. The day wraps according to the length of each month, and the length of February follows a leap rule on the year offset.

Software reaches two 32-bit words through a small register port: a time word at address 0 and a date word at address 1. A read of the time word saves a snapshot of the date. The next read of the date word returns that snapshot, so a time/date pair read in that order always belongs together, even when midnight passes between the two reads. Both words can be loaded only while the init-mode input is high. The counter holds still during that time.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the time word reads 0x00000000 (00:00:00), the date word reads 0x00000101 (year 00, month 01, day 01, weekday 0), and rd_valid is low.
- R2: Time word layout: hours tens [21:20], hours units [19:16], minutes tens [14:12], minutes units [11:8], seconds tens [6:4], seconds units [3:0]. Seconds and minutes count 00 to 59 in BCD. A units digit of 9 wraps to 0 and carries into the tens digit.
- R3: Hours count 00 to 23. A tick at 23:59:59 gives 00:00:00 and advances the date by one day.
- R4: Date word layout: year tens [23:20], year units [19:16], weekday [15:13], month tens [12], month units [11:8], day tens [5:4], day units [3:0]. April, June, September and November end on day 30. The other months except February end on day 31. After the last day the date goes to day 01 of the next month.
- R5: February ends on day 29 when the year offset (tens*10+units) is divisible by 4, and on day 28 otherwise.
- R6: The weekday code (Monday=0 to Sunday=6) goes up by one on each day advance, and 6 wraps to 0.
- R7: December 31 goes to January 01 and the year offset goes up by one. Year offset 99 wraps to 00.
- R8: A write (wr_en high, with addr 0 for time and 1 for date) loads the word only while init_mode is high. When init_mode is low the write is ignored.
- R9: While init_mode is high, ticks do not advance the counter. The first tick after init_mode falls advances it by one second.
- R10: A read with rd_en high and a given addr returns the word on rd_data, with rd_valid high, in the cycle after the request.
- R11: A time read saves the current date. The next date read returns that saved date, even if the date has changed since, and clears the lock. A date read with no lock pending returns the live date.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle enable for each second |
| init_mode | input | 1 | Permits writes and stops counting |
| addr | input | 1 | Word select: 0 time, 1 date |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | High in the cycle after a read |

## Verification
The carry chain is exercised from several start points:
- a mid-minute tick, where only the seconds units digit moves;
- 23:59:59, which carries through every time digit into the date;
- four month ends: a 30-day month, a 31-day month, February in a leap year and February in a non-leap year;
- December 31 at year offset 99, which carries into the year.

Each start point isolates one carry path, so a wrong month length, a wrong leap decision or a lost carry each produces a different wrong date. Writes made outside init mode and ticks made inside init mode check the gating. A time read followed by a midnight tick and then two date reads shows the difference between the frozen snapshot and the live date.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;
   localparam int WORD_W = 32;

   typedef struct packed {
      logic [1:0] hr_t;
      logic [3:0] hr_u;
      logic [2:0] mn_t;
      logic [3:0] mn_u;
      logic [2:0] sc_t;
      logic [3:0] sc_u;
   } tod_t;

   typedef struct packed {
      logic [3:0] yr_t;
      logic [3:0] yr_u;
      logic [2:0] wkd;
      logic       mo_t;
      logic [3:0] mo_u;
      logic [1:0] dy_t;
      logic [3:0] dy_u;
   } cal_t;

   function automatic logic [WORD_W-1:0] tod_to_word(tod_t t);
      return {10'b0, t.hr_t, t.hr_u, 1'b0, t.mn_t, t.mn_u, 1'b0, t.sc_t, t.sc_u};
   endfunction

   function automatic tod_t word_to_tod(logic [WORD_W-1:0] w);
      tod_t t;
      t.hr_t = w[21:20]; t.hr_u = w[19:16];
      t.mn_t = w[14:12]; t.mn_u = w[11:8];
      t.sc_t = w[6:4];   t.sc_u = w[3:0];
      return t;
   endfunction

   function automatic logic [WORD_W-1:0] cal_to_word(cal_t c);
      return {8'b0, c.yr_t, c.yr_u, c.wkd, c.mo_t, c.mo_u, 2'b0, c.dy_t, c.dy_u};
   endfunction

   function automatic cal_t word_to_cal(logic [WORD_W-1:0] w);
      cal_t c;
      c.yr_t = w[23:20]; c.yr_u = w[19:16];
      c.wkd  = w[15:13]; c.mo_t = w[12];
      c.mo_u = w[11:8];  c.dy_t = w[5:4];
      c.dy_u = w[3:0];
      return c;
   endfunction
endpackage

// File: rtl/bcd_cal_tod.sv
module bcd_cal_tod
   import bcd_cal_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   input  logic load,
   input  tod_t load_val,
   output tod_t cur,
   output logic day_carry
);
   tod_t nxt;
   logic sc_end, mn_end, hr_end;

   assign sc_end = (cur.sc_u == 4'd9) && (cur.sc_t == 3'd5);
   assign mn_end = (cur.mn_u == 4'd9) && (cur.mn_t == 3'd5);
   assign hr_end = (cur.hr_u == 4'd3) && (cur.hr_t == 2'd2);
   assign day_carry = step && sc_end && mn_end && hr_end;

   always_comb begin
      nxt = cur;
      if (cur.sc_u != 4'd9) nxt.sc_u = cur.sc_u + 4'd1;
      else begin
         nxt.sc_u = 4'd0;
         if (!sc_end) nxt.sc_t = cur.sc_t + 3'd1;
         else begin
            nxt.sc_t = 3'd0;
            if (cur.mn_u != 4'd9) nxt.mn_u = cur.mn_u + 4'd1;
            else begin
               nxt.mn_u = 4'd0;
               if (!mn_end) nxt.mn_t = cur.mn_t + 3'd1;
               else begin
                  nxt.mn_t = 3'd0;
                  if (hr_end) begin
                     nxt.hr_t = 2'd0;
                     nxt.hr_u = 4'd0;
                  end else if (cur.hr_u == 4'd9) begin
                     nxt.hr_u = 4'd0;
                     nxt.hr_t = cur.hr_t + 2'd1;
                  end else begin
                     nxt.hr_u = cur.hr_u + 4'd1;
                  end
               end
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    cur <= '0;
      else if (load) cur <= load_val;
      else if (step) cur <= nxt;
   end
endmodule

// File: rtl/bcd_cal_date.sv
module bcd_cal_date
   import bcd_cal_pkg::*;
#(
   parameter int WEEK_DAYS = 7,
   parameter bit LEAP_EN   = 1'b1
)(
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   input  logic load,
   input  cal_t load_val,
   output cal_t cur
);
   localparam logic [2:0] WD_LAST = 3'(WEEK_DAYS - 1);

   cal_t       nxt;
   logic [3:0] mo_bin;
   logic [6:0] yr_bin;
   logic       leap;
   logic [5:0] last_day;
   logic       at_end;

   assign mo_bin = cur.mo_t ? (cur.mo_u + 4'd10) : cur.mo_u;
   assign yr_bin = {3'b0, cur.yr_t} * 7'd10 + {3'b0, cur.yr_u};

   generate
      if (LEAP_EN) begin : g_leap
         assign leap = (yr_bin[1:0] == 2'b00);
      end else begin : g_noleap
         assign leap = 1'b0;
      end
   endgenerate

   always_comb begin
      case (mo_bin)
         4'd2:                      last_day = leap ? 6'h29 : 6'h28;
         4'd4, 4'd6, 4'd9, 4'd11:   last_day = 6'h30;
         default:                   last_day = 6'h31;
      endcase
   end

   assign at_end = ({cur.dy_t, cur.dy_u} == last_day);

   always_comb begin
      nxt = cur;
      nxt.wkd = (cur.wkd >= WD_LAST) ? 3'd0 : cur.wkd + 3'd1;
      if (!at_end) begin
         if (cur.dy_u == 4'd9) begin
            nxt.dy_u = 4'd0;
            nxt.dy_t = cur.dy_t + 2'd1;
         end else begin
            nxt.dy_u = cur.dy_u + 4'd1;
         end
      end else begin
         nxt.dy_t = 2'd0;
         nxt.dy_u = 4'd1;
         if (cur.mo_t && cur.mo_u == 4'd2) begin
            nxt.mo_t = 1'b0;
            nxt.mo_u = 4'd1;
            if (cur.yr_u != 4'd9) nxt.yr_u = cur.yr_u + 4'd1;
            else begin
               nxt.yr_u = 4'd0;
               nxt.yr_t = (cur.yr_t == 4'd9) ? 4'd0 : cur.yr_t + 4'd1;
            end
         end else if (cur.mo_u == 4'd9) begin
            nxt.mo_t = 1'b1;
            nxt.mo_u = 4'd0;
         end else begin
            nxt.mo_u = cur.mo_u + 4'd1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur      <= '0;
         cur.mo_u <= 4'd1;
         cur.dy_u <= 4'd1;
      end else if (load) cur <= load_val;
      else if (step)     cur <= nxt;
   end
endmodule

// File: rtl/bcd_cal_reader.sv
module bcd_cal_reader
   import bcd_cal_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              addr,
   input  logic [WORD_W-1:0] tod_word,
   input  logic [WORD_W-1:0] cal_word,
   output logic [WORD_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              locked
);
   logic [WORD_W-1:0] snap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
         locked   <= 1'b0;
         snap     <= '0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) begin
            if (!addr) begin
               rd_data <= tod_word;
               snap    <= cal_word;
               locked  <= 1'b1;
            end else begin
               rd_data <= locked ? snap : cal_word;
               locked  <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
   import bcd_cal_pkg::*;
#(
   parameter int WEEK_DAYS = 7,
   parameter bit LEAP_EN   = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1hz,
   input  logic              init_mode,
   input  logic              addr,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [WORD_W-1:0] rd_data,
   output logic              rd_valid
);
   generate
      if (WEEK_DAYS < 2 || WEEK_DAYS > 8) begin : g_bad_week
         $error("WEEK_DAYS must lie in 2..8");
      end
   endgenerate

   tod_t tod_q;
   cal_t cal_q;
   logic step, load_tod, load_cal, day_carry, locked;

   assign step     = tick_1hz & ~init_mode;
   assign load_tod = wr_en & init_mode & ~addr;
   assign load_cal = wr_en & init_mode &  addr;

   bcd_cal_tod tod_i (
      .clk(clk), .rst_n(rst_n), .step(step), .load(load_tod),
      .load_val(word_to_tod(wr_data)), .cur(tod_q), .day_carry(day_carry)
   );

   bcd_cal_date #(.WEEK_DAYS(WEEK_DAYS), .LEAP_EN(LEAP_EN)) date_i (
      .clk(clk), .rst_n(rst_n), .step(day_carry), .load(load_cal),
      .load_val(word_to_cal(wr_data)), .cur(cal_q)
   );

   bcd_cal_reader rd_i (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr),
      .tod_word(tod_to_word(tod_q)), .cal_word(cal_to_word(cal_q)),
      .rd_data(rd_data), .rd_valid(rd_valid), .locked(locked)
   );
endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk
   import bcd_cal_pkg::*;
#(
   parameter int WEEK_DAYS = 7
)(
   input logic clk,
   input logic rst_n,
   input logic init_mode,
   input logic load_tod,
   input logic rd_en,
   input logic rd_valid,
   input logic locked,
   input logic addr,
   input tod_t tod_q,
   input cal_t cal_q
);
   a_r2_bcd_ms: assert property (@(posedge clk) disable iff (!rst_n)
      (tod_q.sc_u <= 4'd9 && tod_q.sc_t <= 3'd5 && tod_q.mn_u <= 4'd9 && tod_q.mn_t <= 3'd5));

   a_r3_hour_range: assert property (@(posedge clk) disable iff (!rst_n)
      (tod_q.hr_u <= 4'd9 && {tod_q.hr_t, tod_q.hr_u} <= 6'h23));

   a_r4_date_range: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_q.dy_u <= 4'd9 && {cal_q.dy_t, cal_q.dy_u} != 6'h00 && {cal_q.dy_t, cal_q.dy_u} <= 6'h31
       && {cal_q.mo_t, cal_q.mo_u} != 5'h00 && {cal_q.mo_t, cal_q.mo_u} <= 5'h12));

   a_r6_weekday_range: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(cal_q.wkd) < WEEK_DAYS));

   a_r9_init_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (init_mode && !load_tod) |=> $stable(tod_q));

   a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);

   a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid);

   a_r11_lock_set: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !addr) |=> locked);

   a_r11_lock_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr) |=> !locked);
endmodule

bind bcd_calendar bcd_calendar_chk #(.WEEK_DAYS(WEEK_DAYS)) chk_i (
   .clk(clk), .rst_n(rst_n), .init_mode(init_mode), .load_tod(load_tod),
   .rd_en(rd_en), .rd_valid(rd_valid), .locked(locked), .addr(addr),
   .tod_q(tod_q), .cal_q(cal_q)
);

// File: tb/bcd_calendar_tb.sv
module bcd_calendar_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_1hz = 1'b0;
   logic        init_mode = 1'b0;
   logic        addr = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [31:0] rd_data;
   logic        rd_valid;

   always #(CLK_PERIOD/2) clk = ~clk;

   bcd_calendar dut_i (
      .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .init_mode(init_mode),
      .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
      .rd_data(rd_data), .rd_valid(rd_valid)
   );

   typedef struct { logic [31:0] exp; string tag; } item_t;
   item_t sb[$];
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   int h, m, s, y, mo, d, wd;
   bit lock_b = 1'b0;
   logic [31:0] snap_b;

   function automatic logic [31:0] tw(int hh, int mm, int ss);
      return 32'((hh/10) << 20 | (hh%10) << 16 | (mm/10) << 12 | (mm%10) << 8 | (ss/10) << 4 | ss%10);
   endfunction

   function automatic logic [31:0] dw(int yy, int mm, int dd, int ww);
      return 32'((yy/10) << 20 | (yy%10) << 16 | ww << 13 | (mm/10) << 12 | (mm%10) << 8 | (dd/10) << 4 | dd%10);
   endfunction

   function automatic int dim(int mm, int yy);
      if (mm == 2) return (yy % 4 == 0) ? 29 : 28;
      if (mm == 4 || mm == 6 || mm == 9 || mm == 11) return 30;
      return 31;
   endfunction

   task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk) tick_1hz = 1'b1;
      @(negedge clk) tick_1hz = 1'b0;
      if (!init_mode) begin
         s++;
         if (s == 60) begin
            s = 0; m++;
            if (m == 60) begin
               m = 0; h++;
               if (h == 24) begin
                  h = 0;
                  wd = (wd == 6) ? 0 : wd + 1;
                  if (d == dim(mo, y)) begin
                     d = 1;
                     if (mo == 12) begin mo = 1; y = (y == 99) ? 0 : y + 1; end
                     else mo++;
                  end else d++;
               end
            end
         end
      end
   endtask

   task automatic wr(bit a, logic [31:0] v);
      @(negedge clk) wr_en = 1'b1; addr = a; wr_data = v;
      @(negedge clk) wr_en = 1'b0;
   endtask

   task automatic set_all(int hh, int mm, int ss, int yy, int mn, int dd, int ww);
      @(negedge clk) init_mode = 1'b1;
      wr(1'b0, tw(hh, mm, ss));
      wr(1'b1, dw(yy, mn, dd, ww));
      @(negedge clk) init_mode = 1'b0;
      h = hh; m = mm; s = ss; y = yy; mo = mn; d = dd; wd = ww;
   endtask

   task automatic rd_time(string tag);
      @(negedge clk) rd_en = 1'b1; addr = 1'b0;
      sb.push_back('{tw(h, m, s), tag});
      snap_b = dw(y, mo, d, wd); lock_b = 1'b1;
      @(negedge clk) rd_en = 1'b0;
   endtask

   task automatic rd_date(string tag);
      @(negedge clk) rd_en = 1'b1; addr = 1'b1;
      sb.push_back('{lock_b ? snap_b : dw(y, mo, d, wd), tag});
      lock_b = 1'b0;
      @(negedge clk) rd_en = 1'b0;
   endtask

   always @(negedge clk) begin
      if (rd_valid) begin
         if (sb.size() == 0) begin
            checks++; errors++;
            $display("FAIL R10: actual=unexpected rd_valid expected=no read response");
         end else begin
            item_t it;
            it = sb.pop_front();
            check(rd_data, it.exp, it.tag);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      h = 0; m = 0; s = 0; y = 0; mo = 1; d = 1; wd = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check({31'b0, rd_valid}, 32'd0, "R1 rd_valid");
      rd_time("R1 time");
      rd_date("R1 date");

      set_all(10, 20, 30, 24, 2, 28, 2);
      tick();
      rd_time("R2 seconds step");
      rd_date("R10 date read");
      set_all(10, 29, 59, 24, 2, 28, 2);
      tick();
      rd_time("R2 minute carry");

      wr(1'b0, tw(5, 5, 5));
      rd_time("R8 write ignored");
      rd_date("R11 clear");

      @(negedge clk) init_mode = 1'b1;
      tick(); tick();
      rd_time("R9 hold in init");
      @(negedge clk) init_mode = 1'b0;
      tick();
      rd_time("R9 resume");
      rd_date("R11 clear");

      set_all(23, 59, 59, 24, 2, 28, 6);
      tick();
      rd_time("R3 midnight");
      rd_date("R5 leap feb28->29 R6 wrap");
      set_all(23, 59, 59, 24, 2, 29, 0);
      tick();
      rd_date("R5 leap feb29->mar01");
      set_all(23, 59, 59, 23, 2, 28, 1);
      tick();
      rd_date("R5 nonleap feb28->mar01");
      set_all(23, 59, 59, 24, 4, 30, 3);
      tick();
      rd_date("R4 30-day month");
      set_all(23, 59, 59, 24, 1, 31, 3);
      tick();
      rd_date("R4 31-day month");
      set_all(23, 59, 59, 24, 9, 30, 3);
      tick();
      rd_date("R4 month tens carry");
      set_all(23, 59, 59, 99, 12, 31, 4);
      tick();
      rd_time("R3 midnight");
      rd_date("R7 year wrap");

      set_all(23, 59, 58, 24, 12, 31, 3);
      tick();
      rd_time("R11 time before midnight");
      tick();
      rd_date("R11 frozen snapshot");
      rd_date("R11 live after release");

      repeat (4) @(negedge clk);
      if (sb.size() != 0) begin
         checks++; errors++;
         $display("FAIL R10: actual=%0d pending expected=0", sb.size());
      end
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule